// File: doc/BRIEF.md
# Configurable PLD Logic Block

This block is a behavioural, synthesizable model of one logic block from a small programmable logic device. It receives 18 signals from a global routing bus, evaluates 22 programmable product terms over them, and drives four macrocell outputs. Each output either takes a fast path, the OR of a fixed group of four product terms, or a wide path, the OR of any chosen subset of the 20 logic terms followed by an XOR with a dedicated term. Each output is then either passed straight through or captured in a register.

The four outputs go back to the routing bus outside the block, so a counter or a state machine is built by feeding them back as inputs. The register clock is chosen for the whole block: one of three global clocks, or a clock formed by a product term. A dedicated product term can clear the registers. An active-low global reset clears the registers and the whole configuration.

Configuration enters through a word-wide write port with a valid/ready handshake. A word is accepted only on a clock edge where both valid and ready are high. No back-pressure occurs in normal operation: ready is low only during reset and is high from the first clock after reset. Writes go to a shadow copy, and the logic uses nothing written until a commit strobe copies the shadow copy into the working configuration.

Top module: `pld_logic_block`

## Requirements
- R1: Input j drives literal bit 2j (true) and literal bit 2j+1 (complement) of a 36-bit term mask. A term is the AND of its enabled literals. A term with no literal enabled is 0.
- R2: With cell word bit 20 clear, cell i outputs the OR of terms 4i to 4i+3.
- R3: With cell word bit 20 set, cell i outputs (OR of the terms whose bit is set in cell word bits 19:0) XOR term 16+i.
- R4: Cell word bit 22 inverts the selected path. Cell word bit 21 selects the register output; when clear, the output follows its inputs in the same cycle. Each cell chooses independently.
- R5: Block word bits 1:0 select the register clock: values 0, 1 and 2 pick global clocks 0, 1 and 2.
- R6: Block clock select value 3 clocks the registers on each rising edge of term 20.
- R7: When block word bit 2 is set and term 21 is 1, all registers are held at 0, and this overrides any clock edge.
- R8: While rst_n is low, all registers and the whole configuration (shadow and working) are 0 and cfg_ready is 0. With the cleared configuration every output is 0.
- R9: Term t mask bits 31:0 are at address 2t and bits 35:32 at address 2t+1. Cell i is at address 44+i and the block word at address 48. Written words change nothing until cfg_commit is sampled high on a cfg_clk edge.
- R10: A word is written only on a cfg_clk edge where cfg_valid and cfg_ready are both high. cfg_ready goes high on the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration port clock |
| rst_n | input | 1 | Active-low global reset |
| glb_clk | input | 3 | Three global register clocks |
| route_in | input | 18 | Signals from the global routing bus |
| cfg_valid | input | 1 | Configuration word valid |
| cfg_ready | output | 1 | Configuration port ready |
| cfg_addr | input | 6 | Configuration word address |
| cfg_data | input | 32 | Configuration word |
| cfg_commit | input | 1 | Copy shadow configuration into working configuration |
| cell_out | output | 4 | Macrocell outputs, fed back to the routing bus outside |

## Verification
The bench loads a mixed configuration and drives the inputs through a set of patterns. This exposes a term with no literals that evaluates to 1: the inverted empty cell would then read 0. It also exposes a mis-wired XOR term, which flips the wide-path output, and a cell whose mode leaks to its neighbour, which shifts by one cycle an output that should not be registered.

It then loads a 4-bit counter through feedback into the shadow copy and checks that the old logic still runs until the commit. Next it holds the reset term across clock edges, where a clock that won over the reset would start counting. It steps through each clock source and expects exact counts: 0 for the idle clock, 4 in 8 cycles for the half-rate clock, and one count per term-clock pulse. Finally it drives one word with valid low and checks that the word is not written.

// File: rtl/pld_lb_pkg.sv
package pld_lb_pkg;
  localparam int unsigned DEF_N_IN     = 18;
  localparam int unsigned DEF_N_CELL   = 4;
  localparam int unsigned DEF_N_SUM_PT = 20;
  localparam int unsigned DEF_BYP      = 4;
  localparam int unsigned DEF_N_GCLK   = 3;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_ADDR_W   = 6;

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/pld_cfg_store.sv
module pld_cfg_store #(
  parameter int N_PT   = 22,
  parameter int LIT_W  = 36,
  parameter int N_CELL = 4,
  parameter int CELL_W = 23,
  parameter int BLK_W  = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int WPT    = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_valid,
  output logic                             wr_ready,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             commit,
  output logic [N_PT-1:0][LIT_W-1:0]       act_pt,
  output logic [N_CELL-1:0][CELL_W-1:0]    act_cell,
  output logic [BLK_W-1:0]                 act_blk
);
  localparam int CELL_BASE = N_PT * WPT;
  localparam int BLK_ADDR  = CELL_BASE + N_CELL;

  logic [N_PT-1:0][LIT_W-1:0]    sh_pt;
  logic [N_CELL-1:0][CELL_W-1:0] sh_cell;
  logic [BLK_W-1:0]              sh_blk;
  logic                          rdy;
  int                            a;

  assign wr_ready = rdy;
  always_comb a = int'(wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_pt    <= '0;
      sh_cell  <= '0;
      sh_blk   <= '0;
      act_pt   <= '0;
      act_cell <= '0;
      act_blk  <= '0;
      rdy      <= 1'b0;
    end else begin
      rdy <= 1'b1;
      if (wr_valid && rdy) begin
        for (int t = 0; t < N_PT; t++)
          for (int l = 0; l < LIT_W; l++)
            if (a == t * WPT + l / DATA_W) sh_pt[t][l] <= wr_data[l % DATA_W];
        for (int c = 0; c < N_CELL; c++)
          if (a == CELL_BASE + c) sh_cell[c] <= wr_data[CELL_W-1:0];
        if (a == BLK_ADDR) sh_blk <= wr_data[BLK_W-1:0];
      end
      if (commit) begin
        act_pt   <= sh_pt;
        act_cell <= sh_cell;
        act_blk  <= sh_blk;
      end
    end
  end
endmodule

// File: rtl/pld_pterm_array.sv
module pld_pterm_array #(
  parameter int N_IN = 18,
  parameter int N_PT = 22
) (
  input  logic [N_IN-1:0]                in_vec,
  input  logic [N_PT-1:0][2*N_IN-1:0]    mask,
  output logic [N_PT-1:0]                pt
);
  localparam int LIT_W = 2 * N_IN;
  logic [LIT_W-1:0] lit;

  for (genvar j = 0; j < N_IN; j++) begin : g_lit
    assign lit[2*j]   = in_vec[j];
    assign lit[2*j+1] = ~in_vec[j];
  end

  // an empty mask yields 0 so unused terms add nothing to a sum
  for (genvar t = 0; t < N_PT; t++) begin : g_term
    assign pt[t] = (|mask[t]) & (&(lit | ~mask[t]));
  end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell #(
  parameter int N_SUM_PT = 20,
  parameter int N_CELL   = 4,
  parameter int BYP      = 4,
  parameter int CELL     = 0
) (
  input  logic                clk,
  input  logic                clr_n,
  input  logic [N_SUM_PT-1:0] sum_pt,
  input  logic [N_SUM_PT-1:0] share,
  input  logic                wide_sel,
  input  logic                reg_sel,
  input  logic                invert,
  output logic                q,
  output logic                y
);
  localparam int XOR_T = N_SUM_PT - N_CELL + CELL;

  logic byp_sum, wide_sum, d;

  assign byp_sum  = |sum_pt[CELL*BYP +: BYP];
  assign wide_sum = (|(sum_pt & share)) ^ sum_pt[XOR_T];
  assign d        = (wide_sel ? wide_sum : byp_sum) ^ invert;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= 1'b0;
    else        q <= d;
  end

  assign y = reg_sel ? q : d;
endmodule

// File: rtl/pld_logic_block.sv
module pld_logic_block
  import pld_lb_pkg::*;
#(
  parameter int N_IN     = DEF_N_IN,
  parameter int N_CELL   = DEF_N_CELL,
  parameter int N_SUM_PT = DEF_N_SUM_PT,
  parameter int BYP      = DEF_BYP,
  parameter int N_GCLK   = DEF_N_GCLK,
  parameter int DATA_W   = DEF_DATA_W,
  parameter int ADDR_W   = DEF_ADDR_W
) (
  input  logic              cfg_clk,
  input  logic              rst_n,
  input  logic [N_GCLK-1:0] glb_clk,
  input  logic [N_IN-1:0]   route_in,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              cfg_commit,
  output logic [N_CELL-1:0] cell_out
);
  localparam int LIT_W  = 2 * N_IN;
  localparam int WPT    = int'(ceil_div(LIT_W, DATA_W));
  localparam int N_PT   = N_SUM_PT + 2;
  localparam int CLK_T  = N_SUM_PT;
  localparam int RST_T  = N_SUM_PT + 1;
  localparam int CELL_W = N_SUM_PT + 3;
  localparam int CSEL_W = $clog2(N_GCLK + 1);
  localparam int BLK_W  = CSEL_W + 1;
  localparam int ACT_W  = N_PT * LIT_W + N_CELL * CELL_W + BLK_W;

  logic [N_PT-1:0][LIT_W-1:0]    act_pt;
  logic [N_CELL-1:0][CELL_W-1:0] act_cell;
  logic [BLK_W-1:0]              act_blk;
  logic [N_PT-1:0]               pt_all;
  logic [CSEL_W-1:0]             clk_sel;
  logic                          rst_en, rst_term, blk_clk, clr_n;
  logic [N_CELL-1:0]             cell_q;

  pld_cfg_store #(
    .N_PT(N_PT), .LIT_W(LIT_W), .N_CELL(N_CELL), .CELL_W(CELL_W),
    .BLK_W(BLK_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WPT(WPT)
  ) u_store (
    .clk(cfg_clk), .rst_n(rst_n), .wr_valid(cfg_valid), .wr_ready(cfg_ready),
    .wr_addr(cfg_addr), .wr_data(cfg_data), .commit(cfg_commit),
    .act_pt(act_pt), .act_cell(act_cell), .act_blk(act_blk)
  );

  pld_pterm_array #(.N_IN(N_IN), .N_PT(N_PT)) u_array (
    .in_vec(route_in), .mask(act_pt), .pt(pt_all)
  );

  assign clk_sel  = act_blk[CSEL_W-1:0];
  assign rst_en   = act_blk[CSEL_W];
  assign rst_term = pt_all[RST_T];
  assign clr_n    = rst_n & ~(rst_en & rst_term);

  always_comb begin
    blk_clk = pt_all[CLK_T];
    for (int g = 0; g < N_GCLK; g++)
      if (int'(clk_sel) == g) blk_clk = glb_clk[g];
  end

  for (genvar c = 0; c < N_CELL; c++) begin : g_cell
    pld_macrocell #(
      .N_SUM_PT(N_SUM_PT), .N_CELL(N_CELL), .BYP(BYP), .CELL(c)
    ) u_mc (
      .clk(blk_clk), .clr_n(clr_n),
      .sum_pt(pt_all[N_SUM_PT-1:0]),
      .share(act_cell[c][N_SUM_PT-1:0]),
      .wide_sel(act_cell[c][N_SUM_PT]),
      .reg_sel(act_cell[c][N_SUM_PT+1]),
      .invert(act_cell[c][N_SUM_PT+2]),
      .q(cell_q[c]), .y(cell_out[c])
    );
  end
endmodule

// File: rtl/pld_logic_block_chk.sv
module pld_logic_block_chk #(
  parameter int N_CELL = 4,
  parameter int ACT_W  = 1
) (
  input logic              cfg_clk,
  input logic              rst_n,
  input logic              cfg_ready,
  input logic              cfg_commit,
  input logic [N_CELL-1:0] cell_out,
  input logic [N_CELL-1:0] cell_q,
  input logic              rst_en,
  input logic              rst_term,
  input logic [ACT_W-1:0]  act
);
  AST_IDLE_AFTER_RST: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    $rose(cfg_ready) |-> cell_out == '0);  // R8

  AST_CFG_HELD: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !cfg_commit |=> $stable(act));  // R9

  AST_READY_UP: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    $past(rst_n) |-> cfg_ready);  // R10

  AST_TERM_CLEAR: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (rst_en && rst_term) |-> cell_q == '0);  // R7
endmodule

bind pld_logic_block pld_logic_block_chk #(.N_CELL(N_CELL), .ACT_W(ACT_W)) u_chk (
  .cfg_clk(cfg_clk), .rst_n(rst_n), .cfg_ready(cfg_ready), .cfg_commit(cfg_commit),
  .cell_out(cell_out), .cell_q(cell_q), .rst_en(rst_en), .rst_term(rst_term),
  .act({act_pt, act_cell, act_blk})
);

// File: tb/tb_pld_logic_block.sv
module tb_pld_logic_block;
  logic        clk = 1'b0, clk1 = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] ext = '0;
  logic        loop_en = 1'b0;
  logic        cfg_valid = 1'b0, cfg_commit = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic        cfg_ready;
  logic [3:0]  cell_out;
  logic [17:0] route;
  logic [2:0]  gclk;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [3:0]  q_exp[$];
  logic [3:0]  q_care[$];
  string       q_req[$];
  event        chk_ev;

  always #5 clk = ~clk;
  always @(posedge clk) clk1 <= ~clk1;
  assign gclk  = {1'b0, clk1, clk};
  assign route = loop_en ? {ext[17:4], cell_out} : ext;

  pld_logic_block dut (
    .cfg_clk(clk), .rst_n(rst_n), .glb_clk(gclk), .route_in(route),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_commit(cfg_commit), .cell_out(cell_out)
  );

  function automatic logic [35:0] pos(input int j);
    logic [35:0] m = '0;
    m[2*j] = 1'b1;
    return m;
  endfunction

  function automatic logic [35:0] neg(input int j);
    logic [35:0] m = '0;
    m[2*j+1] = 1'b1;
    return m;
  endfunction

  task automatic check_bit(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic expect_out(input logic [3:0] e, input logic [3:0] care, input string req);
    q_exp.push_back(e);
    q_care.push_back(care);
    q_req.push_back(req);
    -> chk_ev;
  endtask

  initial begin
    logic [3:0] e, m;
    string r;
    forever begin
      @(chk_ev);
      while (q_exp.size() > 0) begin
        e = q_exp.pop_front();
        m = q_care.pop_front();
        r = q_req.pop_front();
        n_chk++;
        if ((cell_out & m) !== (e & m)) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h (mask %h)", r, cell_out & m, e & m, m);
        end
      end
    end
  end

  task automatic cfg_write(input int addr, input logic [31:0] data);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_addr  = addr[5:0];
    cfg_data  = data;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    cfg_commit = 1'b1;
    @(negedge clk);
    cfg_commit = 1'b0;
  endtask

  task automatic write_term(input int t, input logic [35:0] msk);
    cfg_write(2*t, msk[31:0]);
    cfg_write(2*t+1, {28'b0, msk[35:32]});
  endtask

  function automatic logic [2:0] comb_ref(input logic [6:0] v);
    logic a4, a5, a6, a7, a8, a9;
    {a9, a8, a7, a6, a5, a4} = v[5:0];
    return {1'b1, ((a4 & a5) | (a7 & ~a8)) ^ a9, (a4 & a5) | ~a6};
  endfunction

  initial begin
    logic [6:0] v;
    logic       prev10;
    // reset state
    repeat (3) @(negedge clk);
    #2;
    check_bit(cfg_ready, 1'b0, "R8 ready low in reset");
    expect_out(4'h0, 4'hF, "R8 outputs clear in reset");
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk) #2;
    check_bit(cfg_ready, 1'b1, "R10 ready after reset");

    // mixed combinational configuration
    write_term(0, pos(4) | pos(5));
    write_term(1, neg(6));
    write_term(5, pos(7) | neg(8));
    write_term(17, pos(9));
    write_term(12, pos(10));
    cfg_write(44, 32'h0);
    cfg_write(45, (32'h1 << 20) | 32'h21);
    cfg_write(46, 32'h1 << 22);
    cfg_write(47, 32'h1 << 21);
    cfg_write(48, 32'h0);
    commit();
    @(negedge clk);
    prev10 = 1'b0;
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      v = 7'((p * 23 + 11) % 128);
      ext[10:4] = v;
      #2;
      expect_out({1'b0, comb_ref(v)}, 4'h1, "R2 bypass sum");
      expect_out({1'b0, comb_ref(v)}, 4'h2, "R3 wide sum xor");
      expect_out({1'b0, comb_ref(v)}, 4'h4, "R1 empty term inverted");
      expect_out({prev10, 3'b0}, 4'h8, "R4 registered neighbour");
      prev10 = v[6];
    end

    // counter config into shadow only
    write_term(0, pos(0));
    write_term(4, pos(1));
    write_term(8, pos(2));
    write_term(12, pos(3));
    write_term(16, 36'h0);
    write_term(17, pos(0));
    write_term(18, pos(0) | pos(1));
    write_term(19, pos(0) | pos(1) | pos(2));
    write_term(20, pos(16));
    write_term(21, pos(17));
    for (int k = 0; k < 4; k++)
      cfg_write(44 + k, (32'h1 << (4*k)) | (32'h3 << 20) | ((k == 0) ? (32'h1 << 22) : 32'h0));
    cfg_write(48, 32'h4);
    @(negedge clk) #2;
    expect_out({v[6], comb_ref(v)}, 4'hF, "R9 shadow not yet active");
    ext[17] = 1'b1;
    commit();
    loop_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) #2;
      expect_out(4'h0, 4'hF, "R7 reset term beats clock");
    end
    @(negedge clk) ext[17] = 1'b0;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk) #2;
      expect_out(4'(n % 16), 4'hF, "R3 R4 counter step");
    end

    // idle global clock 2
    ext[17] = 1'b1;
    cfg_write(48, 32'h6);
    commit();
    ext[17] = 1'b0;
    repeat (8) @(negedge clk);
    #2;
    expect_out(4'h0, 4'hF, "R5 clock 2 idle");

    // half-rate global clock 1
    ext[17] = 1'b1;
    cfg_write(48, 32'h5);
    commit();
    ext[17] = 1'b0;
    repeat (8) @(negedge clk);
    #2;
    expect_out(4'h4, 4'hF, "R5 clock 1 half rate");

    // product-term clock
    ext[16] = 1'b0;
    ext[17] = 1'b1;
    cfg_write(48, 32'h7);
    commit();
    ext[17] = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    expect_out(4'h0, 4'hF, "R6 no count without term edge");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) ext[16] = 1'b1;
      @(negedge clk) ext[16] = 1'b0;
    end
    #2;
    expect_out(4'h3, 4'hF, "R6 term clock pulses");

    // global reset
    rst_n = 1'b0;
    #1;
    expect_out(4'h0, 4'hF, "R8 global reset clears");
    check_bit(cfg_ready, 1'b0, "R8 ready low in reset");
    @(negedge clk);
    rst_n   = 1'b1;
    loop_en = 1'b0;
    ext     = '0;
    @(negedge clk) #2;
    check_bit(cfg_ready, 1'b1, "R10 ready after reset");
    expect_out(4'h0, 4'hF, "R8 cleared config after reset");

    // a word presented without valid is not taken
    @(negedge clk);
    cfg_addr  = 6'd46;
    cfg_data  = 32'h1 << 22;
    cfg_valid = 1'b0;
    commit();
    #2;
    expect_out(4'h0, 4'h4, "R10 word without valid ignored");
    cfg_write(46, 32'h1 << 22);
    commit();
    #2;
    expect_out(4'h4, 4'h4, "R9 committed word active");

    #5;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule